// File: doc/BRIEF.md
# Clock-Source Boundary-Scan Segment

This block is a ten-cell piece of a boundary-scan data register that covers the five clock sources with off-chip connections. Source 0 is the external clock input, source 1 the crystal or ceramic resonator, source 2 the external RC network, source 3 the low-frequency crystal and source 4 the 32 kHz timer oscillator. Each source has two cells. The first is a controllable cell on the oscillator enable. It has a capture/shift flop and an update latch, and under EXTEST the latch drives the enable in place of the value that comes from digital logic. The second is an observe-only cell on the clock line that comes back from the oscillator. The internal RC oscillator has no pins, so it has no cells.

The TAP controller drives the shift, clock, update and EXTEST controls, which are all sampled on the rising edge of `tck`. All pins are plain control and data pins, because the block has no streaming interface. Only one main clock source may run at a time. An error flag reports when the update latches enable more than one main source during EXTEST. The timer oscillator is not counted by this flag.

Top module: `clk_src_bscan_seg`

## Requirements
- R1: The chain order is fixed. Cell 2i is the enable cell of source i and cell 2i+1 is the clock cell of source i, for i = 0 to 4. `scan_in` feeds cell 0, and `scan_out` is always the value of cell 9.
- R2: On a rising `tck` with `clock_dr`=1 and `shift_dr`=0, cell 2i loads `sys_en[i]` and cell 2i+1 loads `osc_clk[i]`.
- R3: On a rising `tck` with `clock_dr`=1 and `shift_dr`=1, cell 0 loads `scan_in` and each cell k>0 loads the old value of cell k-1.
- R4: On a rising `tck` with `update_dr`=1, the update latch of source i loads the value of cell 2i. Clock cells have no update stage.
- R5: `osc_en[i]` equals the update latch of source i when `extest`=1, and equals `sys_en[i]` when `extest`=0.
- R6: While `trst_n` is low, all ten cells clear to 0 and the update latches take the idle values: 0 for every source except source 2 (external RC), which idles at 1. Together these are the vector 5'b00100.
- R7: `core_clk[i]` follows `osc_clk[i]` combinationally and is never altered by the scan logic.
- R8: When `clock_dr`=0, no cell changes, whatever `shift_dr` and `scan_in` do.
- R9: A source is active when its `osc_en` bit differs from its idle value. `multi_main_err` is 1 only when `extest`=1 and more than one of sources 0 to 3 is active. Source 4 never counts.
- R10: When `update_dr`=0, the update latches hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| shift_dr | input | 1 | Selects shift (1) or capture (0) |
| clock_dr | input | 1 | Enables the capture/shift flops |
| update_dr | input | 1 | Loads the update latches |
| extest | input | 1 | Scan latches drive the oscillator enables |
| scan_in | input | 1 | Serial data from the previous segment |
| scan_out | output | 1 | Serial data to the next segment |
| sys_en | input | 5 | Oscillator enables from digital logic |
| osc_en | output | 5 | Enables driven to the oscillators |
| osc_clk | input | 5 | Clock lines from the oscillators |
| core_clk | output | 5 | Clock lines passed on to system logic |
| multi_main_err | output | 1 | More than one main source enabled under EXTEST |

## Verification
The bench checks the idle state of the external RC enable after reset, because a latch that reset to 0 would quietly turn that source on under EXTEST. It captures mixed enable and clock patterns and shifts them out. This exposes swapped cell pairs or reversed chain order, which would show up as misordered serial bits. The contention cases include an active-low RC enable combined with another source, and the timer oscillator combined with a main source. A guard that ignored the idle polarities would misflag or miss these cases, and so would a guard that counted the timer. Hold phases with `clock_dr` or `update_dr` low catch cells that shift or update when they should not.

// File: rtl/clk_src_bscan_pkg.sv
package clk_src_bscan_pkg;
  localparam int unsigned SRC_COUNT = 5;
  localparam int unsigned CELLS_PER_SRC = 2;
  // idle enable value per source; source 2 (external RC) idles high
  localparam logic [SRC_COUNT-1:0] SRC_IDLE = 5'b00100;
  // sources that count as a main clock for the contention guard
  localparam logic [SRC_COUNT-1:0] SRC_MAIN = 5'b01111;
endpackage

// File: rtl/bsc_ctrl_cell.sv
module bsc_ctrl_cell #(
  parameter logic IDLE_VAL = 1'b0
) (
  input  logic tck,
  input  logic trst_n,
  input  logic clock_dr,
  input  logic shift_dr,
  input  logic update_dr,
  input  logic extest,
  input  logic scan_i,
  input  logic sys_i,
  output logic scan_o,
  output logic func_o
);
  logic cap_q;
  logic upd_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)       cap_q <= 1'b0;
    else if (clock_dr) cap_q <= shift_dr ? scan_i : sys_i;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)        upd_q <= IDLE_VAL;
    else if (update_dr) upd_q <= cap_q;
  end

  assign scan_o = cap_q;
  assign func_o = extest ? upd_q : sys_i;

  p_cell_hold_r8: assert property (@(posedge tck) disable iff (!trst_n)
    !clock_dr |=> $stable(cap_q));
  p_latch_hold_r10: assert property (@(posedge tck) disable iff (!trst_n)
    !update_dr |=> $stable(upd_q));
  p_latch_load_r4: assert property (@(posedge tck) disable iff (!trst_n)
    update_dr |=> (upd_q == $past(cap_q)));
endmodule

// File: rtl/bsc_obs_cell.sv
module bsc_obs_cell (
  input  logic tck,
  input  logic trst_n,
  input  logic clock_dr,
  input  logic shift_dr,
  input  logic scan_i,
  input  logic obs_i,
  output logic scan_o
);
  logic q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)       q <= 1'b0;
    else if (clock_dr) q <= shift_dr ? scan_i : obs_i;
  end

  assign scan_o = q;

  p_obs_capture_r2: assert property (@(posedge tck) disable iff (!trst_n)
    (clock_dr && !shift_dr) |=> (q == $past(obs_i)));
endmodule

// File: rtl/bsc_main_guard.sv
module bsc_main_guard #(
  parameter int unsigned N = 5,
  parameter logic [N-1:0] IDLE = '0,
  parameter logic [N-1:0] MAIN = '1
) (
  input  logic         extest,
  input  logic [N-1:0] en_vec,
  output logic         err
);
  localparam int unsigned CW = $clog2(N + 1);
  logic [N-1:0]  active;
  logic [CW-1:0] n_active;

  always_comb begin
    active   = (en_vec ^ IDLE) & MAIN;
    n_active = '0;
    for (int i = 0; i < N; i++) n_active = n_active + CW'(active[i]);
    err = extest && (n_active > CW'(1));
  end
endmodule

// File: rtl/clk_src_bscan_seg.sv
module clk_src_bscan_seg
  import clk_src_bscan_pkg::*;
#(
  parameter int unsigned N_SRC = SRC_COUNT,
  parameter logic [N_SRC-1:0] IDLE_EN = SRC_IDLE,
  parameter logic [N_SRC-1:0] MAIN_SRC = SRC_MAIN
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             shift_dr,
  input  logic             clock_dr,
  input  logic             update_dr,
  input  logic             extest,
  input  logic             scan_in,
  output logic             scan_out,
  input  logic [N_SRC-1:0] sys_en,
  output logic [N_SRC-1:0] osc_en,
  input  logic [N_SRC-1:0] osc_clk,
  output logic [N_SRC-1:0] core_clk,
  output logic             multi_main_err
);
  localparam int unsigned N_CELL = N_SRC * CELLS_PER_SRC;

  // link[k] is the serial input of cell k; link[N_CELL] leaves the segment
  logic [N_CELL:0] link;
  assign link[0] = scan_in;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    bsc_ctrl_cell #(.IDLE_VAL(IDLE_EN[i])) u_en_cell (
      .tck(tck), .trst_n(trst_n), .clock_dr(clock_dr), .shift_dr(shift_dr),
      .update_dr(update_dr), .extest(extest),
      .scan_i(link[2*i]), .sys_i(sys_en[i]),
      .scan_o(link[2*i+1]), .func_o(osc_en[i])
    );
    bsc_obs_cell u_clk_cell (
      .tck(tck), .trst_n(trst_n), .clock_dr(clock_dr), .shift_dr(shift_dr),
      .scan_i(link[2*i+1]), .obs_i(osc_clk[i]),
      .scan_o(link[2*i+2])
    );
  end

  assign scan_out = link[N_CELL];
  assign core_clk = osc_clk;

  bsc_main_guard #(.N(N_SRC), .IDLE(IDLE_EN), .MAIN(MAIN_SRC)) u_guard (
    .extest(extest), .en_vec(osc_en), .err(multi_main_err)
  );

  p_shift_out_r3: assert property (@(posedge tck) disable iff (!trst_n)
    (clock_dr && shift_dr) |=> (scan_out == $past(link[N_CELL-1])));

  always_comb begin
    if (trst_n && !extest) p_err_needs_extest_r9: assert (!multi_main_err);
  end
endmodule

// File: tb/clk_src_bscan_seg_bench.sv
`timescale 1ns/1ps
module clk_src_bscan_seg_bench;
  logic tck = 0, trst_n = 0, shift_dr = 0, clock_dr = 0, update_dr = 0;
  logic extest = 0, scan_in = 0;
  logic [4:0] sys_en = 0, osc_clk = 0;
  logic scan_out, multi_main_err;
  logic [4:0] osc_en, core_clk;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 tck = ~tck;

  clk_src_bscan_seg u_clk_src_bscan_seg (
    .tck(tck), .trst_n(trst_n), .shift_dr(shift_dr), .clock_dr(clock_dr),
    .update_dr(update_dr), .extest(extest), .scan_in(scan_in),
    .scan_out(scan_out), .sys_en(sys_en), .osc_en(osc_en),
    .osc_clk(osc_clk), .core_clk(core_clk), .multi_main_err(multi_main_err)
  );

  // behavioural reference: a list of ten bits plus five latches
  bit m_cell[10];
  bit [4:0] m_lat;
  localparam bit [4:0] IDLE = 5'b00100;

  always @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      foreach (m_cell[k]) m_cell[k] <= 0;
      m_lat <= IDLE;
    end else begin
      if (clock_dr) begin
        if (shift_dr) begin
          m_cell[0] <= scan_in;
          for (int k = 1; k < 10; k++) m_cell[k] <= m_cell[k-1];
        end else begin
          for (int s = 0; s < 5; s++) begin
            m_cell[2*s]   <= sys_en[s];
            m_cell[2*s+1] <= osc_clk[s];
          end
        end
      end
      if (update_dr)
        for (int s = 0; s < 5; s++) m_lat[s] <= m_cell[2*s];
    end
  end

  function automatic bit exp_err(bit [4:0] en, bit ext);
    int n = 0;
    for (int s = 0; s < 4; s++) if (en[s] != IDLE[s]) n++;
    return ext && (n > 1);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge tck) begin
    if (trst_n && !done) begin
      automatic bit [4:0] e = extest ? m_lat : sys_en;
      check("R3 scan_out", scan_out, m_cell[9]);
      check("R5 osc_en", osc_en, e);
      check("R7 core_clk", core_clk, osc_clk);
      check("R9 multi_main_err", multi_main_err, exp_err(e, extest));
    end
  end

  task automatic tick();
    @(posedge tck); #1;
  endtask

  // word bit c ends in cell c after ten shifts
  task automatic shift_word(bit [9:0] w);
    shift_dr = 1; clock_dr = 1;
    for (int k = 9; k >= 0; k--) begin scan_in = w[k]; tick(); end
    clock_dr = 0; shift_dr = 0;
  endtask

  task automatic load_en(bit [4:0] e);
    automatic bit [9:0] w = 0;
    for (int s = 0; s < 5; s++) w[2*s] = e[s];
    shift_word(w);
    update_dr = 1; tick(); update_dr = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    extest = 1;
    repeat (3) tick();
    // R6: reset values
    check("R6 idle enables", osc_en, 5'b00100);
    check("R6 cells clear", scan_out, 0);
    trst_n = 1; tick();
    check("R6 after release", osc_en, 5'b00100);
    // R7: pass-through
    osc_clk = 5'b10101; #0.5;
    check("R7 clock passes", core_clk, 5'b10101);
    // R2 and R1: capture then read out in chain order
    sys_en = 5'b10110; osc_clk = 5'b01011;
    clock_dr = 1; shift_dr = 0; tick();
    shift_dr = 1;
    for (int j = 0; j < 10; j++) begin
      automatic int c = 9 - j;
      automatic bit e = (c % 2 == 0) ? sys_en[c/2] : osc_clk[c/2];
      check($sformatf("R1 R2 cell %0d", c), scan_out, e);
      scan_in = 0; tick();
    end
    clock_dr = 0; shift_dr = 0;
    // R3: word in, word out
    shift_word(10'b1101001110);
    shift_dr = 1; clock_dr = 1;
    for (int j = 0; j < 10; j++) begin
      check("R3 shift order", scan_out, 10'b1101001110 >> (9 - j) & 1);
      tick();
    end
    clock_dr = 0; shift_dr = 0;
    // R8: clock_dr low holds the cells
    shift_word(10'b1000000000);
    shift_dr = 1;
    for (int j = 0; j < 4; j++) begin scan_in = j[0]; tick(); end
    check("R8 hold", scan_out, 1);
    shift_dr = 0;
    // R4 R5 R9: enables under EXTEST
    load_en(5'b00100); check("R4 idle load", osc_en, 5'b00100);
    check("R9 idle no err", multi_main_err, 0);
    load_en(5'b00101); check("R9 one source", multi_main_err, 0);
    load_en(5'b00111); check("R9 two main", multi_main_err, 1);
    load_en(5'b10001); check("R9 RC low counts", multi_main_err, 1);
    load_en(5'b10101); check("R9 timer exempt", multi_main_err, 0);
    load_en(5'b00000); check("R9 RC alone", multi_main_err, 0);
    // R10: new word without update keeps latches
    load_en(5'b00111);
    shift_word(10'b0101010101);
    check("R10 latch hold", osc_en, 5'b00111);
    // R5: system path when EXTEST is low
    extest = 0; sys_en = 5'b11010; #0.5;
    check("R5 system path", osc_en, 5'b11010);
    check("R9 no err outside extest", multi_main_err, 0);
    tick(); tick();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule